// File: doc/BRIEF.md
# 64-bit Status and Configuration Register Bank

This block sits between a host access port and a multi-channel acquisition datapath. Through one memory-mapped port, software reads and writes a bank of 64-bit registers. The bank has two groups of 128 registers each. The status group is read-only and shows live values from the datapath:

- the ring-buffer address where the next sample will be stored;
- a flag that goes to 1 once the external memory has finished its initial calibration;
- a build timestamp;
- a module identifier.

The configuration group holds two packed 2-bit-per-channel fields for 20 channels: amplifier gain and input source. It also holds a reset-request register that clears itself.

The host side has a write port and a read port. The write port carries byte strobes. A write reaches a register only when all eight byte lanes are written in the same cycle. Narrower accesses, such as 32-bit writes, are discarded. Reads are registered and return data one cycle after the request. Unused index values return zero. The configuration fields are driven straight onto output ports for the analog front end. The reset request appears as a single-cycle pulse.

Top module: `regbank64`

## Requirements
- R1: Address bit 7 selects the group (0 = status, 1 = configuration). Bits 6:0 select the register index 0..127. Every register is 64 bits wide.
- R2: A write takes effect only when `wr_en` is high and all eight bits of `wr_strb` are set. With any other strobe pattern, every configuration register and `soft_rst` are left untouched.
- R3: Write-data bits above a register's field width are ignored. They read back as zero, so the packed configuration registers return zero above bit 39.
- R4: Configuration index 0 holds the gain codes. Channel n uses bits [2n+1:2n]. The codes are 0 = x1, 1 = x2, 2 = x5, 3 = x10. `gain_codes` follows the stored value from the cycle after the write.
- R5: Configuration index 1 holds the input-select codes, packed the same way as the gain codes. The codes are 0 = differential pins, 1 = ground, 2 = unused (stored as written), 3 = calibration voltage. `insel_codes` follows the stored value.
- R6: Configuration index 2 is the reset request. A qualifying write with bit 0 set makes `soft_rst` high for exactly the one cycle after the write. A write with bit 0 clear makes no pulse. This index reads back zero.
- R7: Status index 0 returns `ring_wptr`, index 1 returns `calib_done` in bit 0, index 2 returns `build_time` and index 3 returns `module_id`. Each value is zero-extended to 64 bits.
- R8: `rd_data` is loaded on the clock edge where `rd_en` is high and holds its value otherwise. A read of an unimplemented index in either group returns zero.
- R9: After reset, every configuration register is zero, `soft_rst` is low and `rd_data` is zero.
- R10: Writes addressed to the status group have no effect on any configuration register or on `soft_rst`.
- R11: A read and a write to the same configuration register in the same cycle returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write address: group bit and index |
| wr_strb | input | 8 | Byte-lane strobes of the write |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read address: group bit and index |
| rd_data | output | 64 | Registered read data |
| ring_wptr | input | 32 | Next ring-buffer store address |
| calib_done | input | 1 | External memory calibration finished |
| build_time | input | 32 | Build timestamp |
| module_id | input | 32 | Module identifier |
| gain_codes | output | 40 | Packed per-channel gain codes |
| insel_codes | output | 40 | Packed per-channel input-select codes |
| soft_rst | output | 1 | Single-cycle reset request |

## Verification
The assertions check the following on every cycle:

- partial-strobe writes and status-group writes never move the configuration outputs or raise the reset pulse;
- every reset pulse traces back to a qualifying write with bit 0 set;
- a full gain write appears on `gain_codes` one cycle later;
- reads of the write pointer and of unimplemented indices return the right word.

The packing of single channels, the truncation of upper bits on read-back, the read-before-write ordering on the same register, and the one-cycle width of the reset pulse are shown only by the bench's write/read-back sequences.

// File: rtl/regbank64_pkg.sv
package regbank64_pkg;

    localparam int DW     = 64;
    localparam int IDX_W  = 7;
    localparam int ADDR_W = IDX_W + 1;
    localparam int STRB_W = DW / 8;

    typedef enum logic {
        GRP_STATUS = 1'b0,
        GRP_CONFIG = 1'b1
    } grp_e;

    // One-hot write enables produced by the write decoder
    typedef struct packed {
        logic gain;
        logic insel;
        logic rst;
    } wr_dec_t;

endpackage

// File: rtl/regbank64_wdec.sv
module regbank64_wdec
    import regbank64_pkg::*;
#(
    parameter int GAIN_IDX  = 0,
    parameter int INSEL_IDX = 1,
    parameter int RST_IDX   = 2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [STRB_W-1:0] wr_strb,
    output wr_dec_t           dec
);

    logic             full_wr;
    grp_e             grp;
    logic [IDX_W-1:0] idx;

    always_comb begin
        // only a write covering every byte lane qualifies
        full_wr   = wr_en && (wr_strb == {STRB_W{1'b1}});
        grp       = grp_e'(wr_addr[ADDR_W-1]);
        idx       = wr_addr[IDX_W-1:0];
        dec       = '0;
        if (full_wr && grp == GRP_CONFIG) begin
            dec.gain  = (idx == IDX_W'(GAIN_IDX));
            dec.insel = (idx == IDX_W'(INSEL_IDX));
            dec.rst   = (idx == IDX_W'(RST_IDX));
        end
    end

endmodule

// File: rtl/regbank64_cfg.sv
module regbank64_cfg
    import regbank64_pkg::*;
#(
    parameter int NCH    = 20,
    parameter int CODE_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  wr_dec_t               dec,
    input  logic [DW-1:0]         wr_data,
    output logic [NCH*CODE_W-1:0] gain_q_o,
    output logic [NCH*CODE_W-1:0] insel_q_o,
    output logic                  pulse_o
);

    localparam int FW = NCH * CODE_W;

    typedef struct packed {
        logic [FW-1:0] gain;
        logic [FW-1:0] insel;
        logic          pulse;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (dec.gain)
                st_d.gain[ch*CODE_W +: CODE_W] = wr_data[ch*CODE_W +: CODE_W];
            if (dec.insel)
                st_d.insel[ch*CODE_W +: CODE_W] = wr_data[ch*CODE_W +: CODE_W];
        end
        if (dec.rst)
            st_d.pulse = wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gain_q_o  = st_q.gain;
    assign insel_q_o = st_q.insel;
    assign pulse_o   = st_q.pulse;

endmodule

// File: rtl/regbank64_rdmux.sv
module regbank64_rdmux
    import regbank64_pkg::*;
#(
    parameter int FW        = 40,
    parameter int WPTR_W    = 32,
    parameter int TS_W      = 32,
    parameter int ID_W      = 32,
    parameter int GAIN_IDX  = 0,
    parameter int INSEL_IDX = 1,
    parameter int ST_WPTR   = 0,
    parameter int ST_CALIB  = 1,
    parameter int ST_TIME   = 2,
    parameter int ST_ID     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WPTR_W-1:0] ring_wptr,
    input  logic              calib_done,
    input  logic [TS_W-1:0]   build_time,
    input  logic [ID_W-1:0]   module_id,
    input  logic [FW-1:0]     gain_q,
    input  logic [FW-1:0]     insel_q,
    output logic [DW-1:0]     rd_data
);

    typedef struct packed {
        logic [DW-1:0] data;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    grp_e             grp;
    logic [IDX_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        grp  = grp_e'(rd_addr[ADDR_W-1]);
        idx  = rd_addr[IDX_W-1:0];
        if (rd_en) begin
            st_d.data = '0;
            if (grp == GRP_CONFIG) begin
                if (idx == IDX_W'(GAIN_IDX))       st_d.data = DW'(gain_q);
                else if (idx == IDX_W'(INSEL_IDX)) st_d.data = DW'(insel_q);
            end else begin
                if (idx == IDX_W'(ST_WPTR))        st_d.data = DW'(ring_wptr);
                else if (idx == IDX_W'(ST_CALIB))  st_d.data = DW'(calib_done);
                else if (idx == IDX_W'(ST_TIME))   st_d.data = DW'(build_time);
                else if (idx == IDX_W'(ST_ID))     st_d.data = DW'(module_id);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;

endmodule

// File: rtl/regbank64.sv
module regbank64
    import regbank64_pkg::*;
#(
    parameter int NCH       = 20,
    parameter int CODE_W    = 2,
    parameter int WPTR_W    = 32,
    parameter int TS_W      = 32,
    parameter int ID_W      = 32,
    parameter int GAIN_IDX  = 0,
    parameter int INSEL_IDX = 1,
    parameter int RST_IDX   = 2,
    parameter int ST_WPTR   = 0,
    parameter int ST_CALIB  = 1,
    parameter int ST_TIME   = 2,
    parameter int ST_ID     = 3,
    localparam int FW       = NCH * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_strb,
    input  logic [63:0]       wr_data,
    input  logic              rd_en,
    input  logic [7:0]        rd_addr,
    output logic [63:0]       rd_data,
    input  logic [WPTR_W-1:0] ring_wptr,
    input  logic              calib_done,
    input  logic [TS_W-1:0]   build_time,
    input  logic [ID_W-1:0]   module_id,
    output logic [FW-1:0]     gain_codes,
    output logic [FW-1:0]     insel_codes,
    output logic              soft_rst
);

    wr_dec_t dec;

    regbank64_wdec #(
        .GAIN_IDX (GAIN_IDX),
        .INSEL_IDX(INSEL_IDX),
        .RST_IDX  (RST_IDX)
    ) u_wdec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_strb(wr_strb),
        .dec    (dec)
    );

    regbank64_cfg #(
        .NCH   (NCH),
        .CODE_W(CODE_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (dec),
        .wr_data  (wr_data),
        .gain_q_o (gain_codes),
        .insel_q_o(insel_codes),
        .pulse_o  (soft_rst)
    );

    regbank64_rdmux #(
        .FW       (FW),
        .WPTR_W   (WPTR_W),
        .TS_W     (TS_W),
        .ID_W     (ID_W),
        .GAIN_IDX (GAIN_IDX),
        .INSEL_IDX(INSEL_IDX),
        .ST_WPTR  (ST_WPTR),
        .ST_CALIB (ST_CALIB),
        .ST_TIME  (ST_TIME),
        .ST_ID    (ST_ID)
    ) u_rdmux (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .ring_wptr (ring_wptr),
        .calib_done(calib_done),
        .build_time(build_time),
        .module_id (module_id),
        .gain_q    (gain_codes),
        .insel_q   (insel_codes),
        .rd_data   (rd_data)
    );

    // ---------------- assertions ----------------
    logic rd_mapped;
    always_comb begin
        if (rd_addr[7])
            rd_mapped = (rd_addr[6:0] == 7'(GAIN_IDX)) || (rd_addr[6:0] == 7'(INSEL_IDX));
        else
            rd_mapped = (rd_addr[6:0] == 7'(ST_WPTR)) || (rd_addr[6:0] == 7'(ST_CALIB)) ||
                        (rd_addr[6:0] == 7'(ST_TIME)) || (rd_addr[6:0] == 7'(ST_ID));
    end

    // R2: partial-strobe writes leave configuration and pulse untouched
    a_r2_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb != 8'hFF) |=>
            ($stable(gain_codes) && $stable(insel_codes) && !soft_rst));

    // R10: status-group writes have no effect
    a_r10_status_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[7]) |=>
            ($stable(gain_codes) && $stable(insel_codes) && !soft_rst));

    // R6: every pulse comes from a qualifying reset write with bit 0 set
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(wr_en && wr_strb == 8'hFF &&
                           wr_addr == {1'b1, 7'(RST_IDX)} && wr_data[0]));

    // R4: a full gain write appears on the output one cycle later
    a_r4_gain_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == 8'hFF && wr_addr == {1'b1, 7'(GAIN_IDX)}) |=>
            (gain_codes == $past(wr_data[FW-1:0])));

    // R7: write-pointer status read returns the pointer zero-extended
    a_r7_wptr_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == {1'b0, 7'(ST_WPTR)}) |=>
            (rd_data == 64'($past(ring_wptr))));

    // R8: unimplemented index reads zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_mapped) |=> (rd_data == 64'd0));

    // R8: read data holds when no read is requested
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_regbank64.sv
`timescale 1ns/1ps
module tb_regbank64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [7:0]  wr_addr, wr_strb, rd_addr;
    logic [63:0] wr_data, rd_data;
    logic [31:0] ring_wptr, build_time, module_id;
    logic        calib_done;
    logic [39:0] gain_codes, insel_codes;
    logic        soft_rst;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    regbank64 dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_strb(wr_strb), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .ring_wptr(ring_wptr), .calib_done(calib_done),
        .build_time(build_time), .module_id(module_id),
        .gain_codes(gain_codes), .insel_codes(insel_codes), .soft_rst(soft_rst)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic [7:0]  s;
        logic [63:0] d;
        logic [63:0] e;
    } vec_t;

    // write then read back the same address; e = expected read-back
    localparam vec_t VT [8] = '{
        '{8'h80, 8'hFF, 64'h0000_00AA_5555_5555, 64'h0000_00AA_5555_5555},
        '{8'h80, 8'h0F, 64'h0000_0000_0000_1234, 64'h0000_00AA_5555_5555},
        '{8'h80, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_00FF_FFFF_FFFF},
        '{8'h81, 8'hFF, 64'hDEAD_BE00_0000_0003, 64'h0000_0000_0000_0003},
        '{8'h81, 8'h7F, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0003},
        '{8'h81, 8'hFF, 64'h0000_00C0_0000_0000, 64'h0000_00C0_0000_0000},
        '{8'h85, 8'hFF, 64'h0000_0000_0000_0055, 64'h0000_0000_0000_0000},
        '{8'h03, 8'hFF, 64'h1111_2222_3333_4444, 64'h0000_0000_5A5A_0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] s, input logic [63:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_strb = s; wr_data = dat;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
        v = rd_data;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; wr_strb = '0; wr_data = '0; rd_addr = '0;
        ring_wptr = 32'h0001_2340; calib_done = 1'b1;
        build_time = 32'h6512_0F00; module_id = 32'h5A5A_0001;
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 gain", 64'(gain_codes), 64'd0);
        chk("R9 insel", 64'(insel_codes), 64'd0);
        chk("R9 soft_rst", 64'(soft_rst), 64'd0);
        chk("R9 rd_data", rd_data, 64'd0);
        @(negedge clk); rst_n = 1'b1;

        // table: R2 R3 R4 R5 R8 R10
        for (int i = 0; i < 8; i++) begin
            do_wr(VT[i].a, VT[i].s, VT[i].d);
            do_rd(VT[i].a, v);
            chk($sformatf("R2/R3/R4/R5/R8/R10 vec%0d", i), v, VT[i].e);
        end
        chk("R4 gain port", 64'(gain_codes), 64'h0000_00FF_FFFF_FFFF);
        chk("R5 insel port", 64'(insel_codes), 64'h0000_00C0_0000_0000);

        // R4 single channel field: channel 5 = code 2 (x5)
        do_wr(8'h80, 8'hFF, 64'(2) << 10);
        chk("R4 ch5 field", 64'(gain_codes[11:10]), 64'd2);
        chk("R4 other fields", 64'(gain_codes & ~40'hC00), 64'd0);

        // R6 reset pulse
        do_wr(8'h82, 8'hFF, 64'h1);
        chk("R6 pulse high", 64'(soft_rst), 64'd1);
        @(posedge clk); #1;
        chk("R6 pulse one cycle", 64'(soft_rst), 64'd0);
        do_wr(8'h82, 8'hFF, 64'h2);
        chk("R6 bit0 clear no pulse", 64'(soft_rst), 64'd0);
        do_wr(8'h82, 8'h0F, 64'h1);
        chk("R2 partial reset write", 64'(soft_rst), 64'd0);
        do_wr(8'h02, 8'hFF, 64'h1);
        chk("R10 status-group write no pulse", 64'(soft_rst), 64'd0);
        do_rd(8'h82, v);
        chk("R6 reads zero", v, 64'd0);

        // R7 status reads
        do_rd(8'h00, v); chk("R7 wptr", v, 64'h0000_0000_0001_2340);
        do_rd(8'h01, v); chk("R7 calib", v, 64'd1);
        calib_done = 1'b0;
        do_rd(8'h01, v); chk("R7 calib low", v, 64'd0);
        do_rd(8'h02, v); chk("R7 timestamp", v, 64'h0000_0000_6512_0F00);
        do_rd(8'h03, v); chk("R7 module id", v, 64'h0000_0000_5A5A_0001);
        ring_wptr = 32'hFFFF_FFFC;
        do_rd(8'h00, v); chk("R7 wptr zero-extended", v, 64'h0000_0000_FFFF_FFFC);

        // R8 unmapped and hold; R1 group selection
        do_rd(8'h40, v); chk("R8 unmapped status", v, 64'd0);
        do_rd(8'hFF, v); chk("R8 unmapped config", v, 64'd0);
        do_rd(8'h80, v); chk("R1 config idx0", v, 64'(2) << 10);
        @(posedge clk); #1;
        chk("R8 hold", rd_data, 64'(2) << 10);

        // R11 simultaneous read and write of same register
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'h81; wr_strb = 8'hFF; wr_data = 64'h55;
        rd_en = 1'b1; rd_addr = 8'h81;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 old value read", rd_data, 64'h0000_00C0_0000_0000);
        chk("R11 new value stored", 64'(insel_codes), 64'h55);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule